// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block checks one 512-byte data block after it has been read back from flash. It compares the 24-bit check code kept in the spare area with the code freshly computed over the data, and sorts the outcome into one of four classes: clean, a single flipped data bit that can be repaired, damage confined to the check code itself, or an error that cannot be repaired. The spare-area copy is kept bitwise inverted, so the block complements it before the comparison. As a result, an erased page (all ones in the spare area) whose computed code is all zeros checks clean.

Each 24-bit code splits into two 12-bit halves, and XORing matching halves gives an odd and an even syndrome. If the two syndromes are exact 12-bit complements of each other, a single data bit is in error, and the odd syndrome gives its location as a byte offset and a bit index. The result is registered one clock after the start strobe and held until the next strobe. While the block is draining, a downstream data path can pass each byte through a correction port. The port flips the faulty bit when the byte address matches the stored location.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: A code bus carries byte0 in bits [7:0], byte1 in bits [15:8] and byte2 in bits [23:16]. The lower half is bits [11:0] and the upper half is bits [23:12]. The stored code is complemented before use. The odd syndrome is the XOR of the two lower halves and the even syndrome is the XOR of the two upper halves.
- R2: When both syndromes are zero, the status is 2'b00 (clean) and the reported location is byte 0, bit 0.
- R3: When the odd syndrome equals the 12-bit complement of the even syndrome, the status is 2'b01 (data bit repaired). The error byte is odd syndrome bits [11:3] (0 to 511) and the error bit is odd syndrome bits [2:0].
- R4: When the OR of the two syndromes has exactly one bit set, the status is 2'b10 (check code damaged) and the location is zero.
- R5: Any other syndrome gives status 2'b11 (uncorrectable) with location zero.
- R6: A stored code of 24'hFFFFFF compared with a computed code of 24'h000000 gives status 2'b00.
- R7: The done output is high for exactly the cycle after a start cycle. Status and location change only on the clock edge that ends a start cycle, and hold otherwise.
- R8: The correction output equals the correction input XOR (1 << error bit) when the status is 2'b01 and the correction address equals the error byte. In every other case it equals the correction input. This path is combinational.
- R9: After reset, the status is 2'b00, done is low and the location is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Evaluate the codes presented this cycle |
| stored_code_i | input | 24 | Check code as read from the spare area (inverted form) |
| calc_code_i | input | 24 | Check code computed over the data block |
| status_o | output | 2 | Result class: 00 clean, 01 data bit repaired, 10 code damaged, 11 uncorrectable |
| err_byte_o | output | 9 | Byte offset of the faulty data bit |
| err_bit_o | output | 3 | Bit index of the faulty data bit |
| done_o | output | 1 | One-cycle pulse when a new result is valid |
| fix_addr_i | input | 9 | Byte offset of the byte on the correction port |
| fix_data_i | input | 8 | Byte entering the correction port |
| fix_data_o | output | 8 | Byte leaving the correction port, repaired if it is the faulty one |

## Verification
On every cycle, the assertions check the following:
- done follows start by exactly one clock;
- results stay frozen between strobes;
- the location stays zero outside the data-bit class;
- the correction port passes bytes through unchanged unless a data bit was repaired;
- the correction port never flips more than one bit.

Only the bench's scenarios can show that each syndrome pattern lands in the right class with the right offset. These scenarios cover:
- complement pairs at byte 0 bit 0 and at byte 511 bit 7;
- single-bit code damage in either half;
- mixed patterns;
- the erased-page case.
The bench also drives the correction port with matching and non-matching addresses to show that the flip lands on the stored bit.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN      = 2'b00,
        ST_DATA_FIXED = 2'b01,
        ST_CODE_FIXED = 2'b10,
        ST_UNCORR     = 2'b11
    } ecc_status_e;

endpackage

// File: rtl/ecc_code_split.sv
// Complements the stored code, splits both codes into halves, and forms the odd and even syndromes.
module ecc_code_split #(
    parameter int HALF_W = 12
) (
    input  logic [2*HALF_W-1:0] stored_code,
    input  logic [2*HALF_W-1:0] calc_code,
    output logic [HALF_W-1:0]   syn_odd,
    output logic [HALF_W-1:0]   syn_even
);
    logic [2*HALF_W-1:0] stored_true;

    always_comb begin
        stored_true = ~stored_code;
        syn_odd     = stored_true[HALF_W-1:0]        ^ calc_code[HALF_W-1:0];
        syn_even    = stored_true[2*HALF_W-1:HALF_W] ^ calc_code[2*HALF_W-1:HALF_W];
    end
endmodule

// File: rtl/ecc_syn_classify.sv
// Sorts a syndrome pair into one of four result classes and extracts the location.
module ecc_syn_classify
    import ecc_syn_pkg::*;
#(
    parameter int OFS_W = 9,
    parameter int BIT_W = 3,
    localparam int HALF_W = OFS_W + BIT_W
) (
    input  logic [HALF_W-1:0] syn_odd,
    input  logic [HALF_W-1:0] syn_even,
    output ecc_status_e       status,
    output logic [OFS_W-1:0]  ofs,
    output logic [BIT_W-1:0]  bitpos
);
    logic [HALF_W-1:0] syn_or;
    logic              single_bit;

    always_comb begin
        syn_or     = syn_odd | syn_even;
        single_bit = (syn_or != '0) && ((syn_or & (syn_or - 1'b1)) == '0);
        status     = ST_UNCORR;
        ofs        = '0;
        bitpos     = '0;
        if ((syn_odd == '0) && (syn_even == '0)) begin
            status = ST_CLEAN;
        end else if (syn_odd == ~syn_even) begin
            status = ST_DATA_FIXED;
            ofs    = syn_odd[HALF_W-1:BIT_W];
            bitpos = syn_odd[BIT_W-1:0];
        end else if (single_bit) begin
            status = ST_CODE_FIXED;
        end
    end
endmodule

// File: rtl/ecc_byte_fixer.sv
// Flips one bit of a passing byte when its address hits the stored location.
module ecc_byte_fixer #(
    parameter int OFS_W = 9,
    parameter int BIT_W = 3,
    localparam int BYTE_W = 1 << BIT_W
) (
    input  logic              active,
    input  logic [OFS_W-1:0]  err_ofs,
    input  logic [BIT_W-1:0]  err_bit,
    input  logic [OFS_W-1:0]  addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    logic hit;

    assign hit = active && (addr == err_ofs);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
        assign dout[i] = din[i] ^ (hit && (err_bit == BIT_W'(i)));
    end
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
    import ecc_syn_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    parameter int BYTE_W      = 8,
    localparam int OFS_W  = $clog2(BLOCK_BYTES),
    localparam int BIT_W  = $clog2(BYTE_W),
    localparam int HALF_W = OFS_W + BIT_W,
    localparam int CODE_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] stored_code_i,
    input  logic [CODE_W-1:0] calc_code_i,
    output logic [1:0]        status_o,
    output logic [OFS_W-1:0]  err_byte_o,
    output logic [BIT_W-1:0]  err_bit_o,
    output logic              done_o,
    input  logic [OFS_W-1:0]  fix_addr_i,
    input  logic [BYTE_W-1:0] fix_data_i,
    output logic [BYTE_W-1:0] fix_data_o
);
    typedef struct packed {
        ecc_status_e      status;
        logic [OFS_W-1:0] ofs;
        logic [BIT_W-1:0] bitpos;
        logic             done;
    } result_t;

    result_t res_d, res_q;

    logic [HALF_W-1:0] syn_odd, syn_even;
    ecc_status_e       cls_status;
    logic [OFS_W-1:0]  cls_ofs;
    logic [BIT_W-1:0]  cls_bit;

    ecc_code_split #(.HALF_W(HALF_W)) u_split (
        .stored_code (stored_code_i),
        .calc_code   (calc_code_i),
        .syn_odd     (syn_odd),
        .syn_even    (syn_even)
    );

    ecc_syn_classify #(.OFS_W(OFS_W), .BIT_W(BIT_W)) u_classify (
        .syn_odd  (syn_odd),
        .syn_even (syn_even),
        .status   (cls_status),
        .ofs      (cls_ofs),
        .bitpos   (cls_bit)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = start_i;
        if (start_i) begin
            res_d.status = cls_status;
            res_d.ofs    = cls_ofs;
            res_d.bitpos = cls_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    ecc_byte_fixer #(.OFS_W(OFS_W), .BIT_W(BIT_W)) u_fixer (
        .active  (res_q.status == ST_DATA_FIXED),
        .err_ofs (res_q.ofs),
        .err_bit (res_q.bitpos),
        .addr    (fix_addr_i),
        .din     (fix_data_i),
        .dout    (fix_data_o)
    );

    assign status_o   = res_q.status;
    assign err_byte_o = res_q.ofs;
    assign err_bit_o  = res_q.bitpos;
    assign done_o     = res_q.done;
endmodule

// File: rtl/ecc_syn_checker.sv
module ecc_syn_checker #(
    parameter int OFS_W = 9,
    parameter int BIT_W = 3,
    localparam int BYTE_W = 1 << BIT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [1:0]        status_o,
    input logic [OFS_W-1:0]  err_byte_o,
    input logic [BIT_W-1:0]  err_bit_o,
    input logic              done_o,
    input logic [BYTE_W-1:0] fix_data_i,
    input logic [BYTE_W-1:0] fix_data_o
);
    assert_done_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    assert_done_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(status_o) && $stable(err_byte_o) && $stable(err_bit_o)));

    // R2 R4 R5: the location is reported only for a repaired data bit
    assert_loc_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'b01) |-> (err_byte_o == '0 && err_bit_o == '0));

    assert_fix_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'b01) |-> (fix_data_o == fix_data_i));

    assert_fix_single_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fix_data_o ^ fix_data_i) <= 1);
endmodule

bind ecc_syndrome_corrector ecc_syn_checker #(.OFS_W(OFS_W), .BIT_W(BIT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .status_o   (status_o),
    .err_byte_o (err_byte_o),
    .err_bit_o  (err_bit_o),
    .done_o     (done_o),
    .fix_data_i (fix_data_i),
    .fix_data_o (fix_data_o)
);

// File: tb/ecc_syndrome_corrector_tb.sv
`timescale 1ns/1ps
module ecc_syndrome_corrector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] stored_code_i = '0;
    logic [23:0] calc_code_i = '0;
    logic [1:0]  status_o;
    logic [8:0]  err_byte_o;
    logic [2:0]  err_bit_o;
    logic        done_o;
    logic [8:0]  fix_addr_i = '0;
    logic [7:0]  fix_data_i = '0;
    logic [7:0]  fix_data_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ecc_syndrome_corrector u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .stored_code_i(stored_code_i), .calc_code_i(calc_code_i),
        .status_o(status_o), .err_byte_o(err_byte_o), .err_bit_o(err_bit_o),
        .done_o(done_o), .fix_addr_i(fix_addr_i), .fix_data_i(fix_data_i),
        .fix_data_o(fix_data_o)
    );

    typedef struct {
        logic [1:0] st;
        logic [8:0] by;
        logic [2:0] bi;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops an expectation for every done pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb_q.size() == 0) begin
                chk("R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, "status", int'(status_o), int'(e.st));
                chk(e.req, "err_byte", int'(err_byte_o), int'(e.by));
                chk(e.req, "err_bit", int'(err_bit_o), int'(e.bi));
            end
        end
    end

    task automatic drive_raw(input logic [23:0] stored, input logic [23:0] calc,
                             input logic [1:0] st, input logic [8:0] by,
                             input logic [2:0] bi, input string req);
        exp_t e;
        e.st = st; e.by = by; e.bi = bi; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        stored_code_i = stored;
        calc_code_i   = calc;
        start_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R7", "done after one cycle", int'(done_o), 0);
    endtask

    // builds a stored code that yields the given syndrome halves against calc
    task automatic run_case(input logic [11:0] odd, input logic [11:0] even,
                            input logic [23:0] calc, input logic [1:0] st,
                            input logic [8:0] by, input logic [2:0] bi, input string req);
        drive_raw(~(calc ^ {even, odd}), calc, st, by, bi, req);
    endtask

    task automatic fix_probe(input logic [8:0] addr, input logic [7:0] din,
                             input logic [7:0] exp, input string what);
        @(negedge clk);
        fix_addr_i = addr;
        fix_data_i = din;
        #1;
        chk("R8", what, int'(fix_data_o), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset status", int'(status_o), 0);
        chk("R9", "reset done", int'(done_o), 0);
        chk("R9", "reset byte", int'(err_byte_o), 0);
        chk("R9", "reset bit", int'(err_bit_o), 0);

        // R2 clean, R1 with a non-trivial computed code
        run_case(12'h000, 12'h000, 24'h5A3C96, 2'b00, 9'd0, 3'd0, "R2");
        // R3 data bit at byte 0x1A5 bit 6
        run_case(12'hD2E, 12'h2D1, 24'h13579B, 2'b01, 9'h1A5, 3'd6, "R3");
        fix_probe(9'h1A5, 8'h00, 8'h40, "flip set");
        fix_probe(9'h1A5, 8'hFF, 8'hBF, "flip clear");
        fix_probe(9'h1A4, 8'h00, 8'h00, "addr mismatch");

        // R7 hold: inputs change without start
        @(negedge clk);
        stored_code_i = 24'h000000;
        calc_code_i   = 24'hABCDEF;
        repeat (2) @(negedge clk);
        chk("R7", "status held", int'(status_o), 1);
        chk("R7", "byte held", int'(err_byte_o), 9'h1A5);

        // R3 boundaries
        run_case(12'hFFF, 12'h000, 24'h000000, 2'b01, 9'd511, 3'd7, "R3");
        fix_probe(9'd511, 8'h00, 8'h80, "flip top bit");
        run_case(12'h000, 12'hFFF, 24'hFFFFFF, 2'b01, 9'd0, 3'd0, "R3");
        fix_probe(9'd0, 8'h00, 8'h01, "flip bit0");

        // R4 code-only damage in either half, and the same bit in both
        run_case(12'h010, 12'h000, 24'h0F0F0F, 2'b10, 9'd0, 3'd0, "R4");
        fix_probe(9'd0, 8'h5A, 8'h5A, "no flip on code damage");
        run_case(12'h000, 12'h800, 24'h123456, 2'b10, 9'd0, 3'd0, "R4");
        run_case(12'h010, 12'h010, 24'h000000, 2'b10, 9'd0, 3'd0, "R4");

        // R5 uncorrectable patterns
        run_case(12'h001, 12'h002, 24'h654321, 2'b11, 9'd0, 3'd0, "R5");
        run_case(12'h003, 12'h000, 24'h000000, 2'b11, 9'd0, 3'd0, "R5");
        run_case(12'hD2E, 12'h2D0, 24'h000000, 2'b11, 9'd0, 3'd0, "R5");
        fix_probe(9'd0, 8'h33, 8'h33, "no flip on uncorrectable");

        // R6 erased page
        drive_raw(24'hFFFFFF, 24'h000000, 2'b00, 9'd0, 3'd0, "R6");

        repeat (2) @(negedge clk);
        chk("R7", "scoreboard drained", sb_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule